// File: doc/BRIEF.md
# Link-Change Interrupt Controller

This unit sits on the management side of an Ethernet PHY and turns a raw link-state input into an interrupt. The link level arrives asynchronously. It is synchronised and its history is kept, so that any edge (link coming up or going down) latches a link-change event. Software sees three registers through a simple strobe-based read/write port. The status register carries the synchronised link level and a summary interrupt flag. The configuration register carries the pin controls. The interrupt register carries the link-change event together with its enable.

The summary flag is cleared by reading the status register, and writes to that register leave it alone. The flag is only a notification, though. The interrupt pin follows the pending, enabled event, so clearing the flag does not release the pin. The pin is released only when the event itself is cleared by a read of the interrupt register, or when it is masked. Masking hides an event without discarding it. The pin has a programmable active level and an output enable that models a tri-state driver.

Top module: `lnk_irq_ctrl`

## Requirements
- R1: Status register bit 0 reports the link input after a synchroniser of SYNC_STAGES flops. With the default of 2, a change is visible to a read strobed in the third cycle after the input changes.
- R2: Any rising or falling edge of the synchronised link level latches the link-change event (interrupt register bit 13) one cycle after the new level appears in status bit 0.
- R3: A read of the interrupt register returns the event as it stood before the read, then clears it. An edge that arrives in the same cycle as the read wins, and the event stays set.
- R4: Interrupt register bit 5 is the event enable and can be read back. A write to bit 13 is ignored. Writing 0 to the enable masks the event at once and does not discard the latched event.
- R5: The summary flag (status bit 7, active high) is set in the cycle in which "event and enable" becomes true. This covers both a new event and the enabling of one that is already pending.
- R6: A read of the status register clears the summary flag, unless the flag is being set in that same cycle. A write to the status register does not clear it.
- R7: The pin is at its active level exactly while configuration bit 1 (interrupt enable), the event and its enable are all set. Clearing the summary flag does not release it.
- R8: Configuration bit 3 selects the active pin level (1 = active high, 0 = active low). The inactive level is its inverse.
- R9: The output-enable port follows configuration bit 0. When it is 0, the pin is treated as undriven.
- R10: The configuration register reads back bits 3, 1 and 0, and all its other bits read as 0. A read of an address that maps to none of the three registers returns 0.
- R11: Read data is registered. It shows the addressed register one cycle after the read strobe and holds that value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_in | input | 1 | Raw link level from the link detector |
| reg_cs | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read, qualified by reg_cs |
| reg_addr | input | ADDR_W | Register address (status 0x10, configuration 0x11, interrupt 0x12 by default) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq_out | output | 1 | Interrupt pin level |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
A link change reaches status bit 0 two clocks after it is applied. The event, the summary flag and the pin follow one clock later. Register writes take effect on the pin in the next cycle, and read data is due one cycle after the strobe. The bench drives every input on the falling edge and runs a behavioural model that advances on each rising edge. It then compares the read data, pin and output enable against that model at the following falling edge, so every result is sampled at the cycle where it becomes due. Directed reads, including one strobed in exactly the cycle the event lands, check register contents against constants derived from the requirements.

// File: rtl/lnk_irq_pkg.sv
package lnk_irq_pkg;

  // register word width and the field positions inside each register
  localparam int REG_W         = 16;
  localparam int STS_LINK_BIT  = 0;
  localparam int STS_SUM_BIT   = 7;
  localparam int CFG_OE_BIT    = 0;
  localparam int CFG_IE_BIT    = 1;
  localparam int CFG_POL_BIT   = 3;
  localparam int INT_EN_BIT    = 5;
  localparam int INT_EVT_BIT   = 13;

  typedef struct packed {
    logic pol;  // 1 = active-high pin
    logic ie;   // global interrupt enable
    logic oe;   // pin output enable
  } pin_cfg_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STS  = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_INT  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/lnk_irq_sync.sv
module lnk_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_in,
  output logic lnk_sync,
  output logic lnk_edge
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;
  logic              prev_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = link_in;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], link_in};
    end
  endgenerate

  always_comb prev_d = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign lnk_sync = chain_q[STAGES-1];
  assign lnk_edge = chain_q[STAGES-1] ^ prev_q;

endmodule

// File: rtl/lnk_irq_evt.sv
module lnk_irq_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic lnk_edge,
  input  logic rd_int,
  input  logic rd_sts,
  input  logic wr_int,
  input  logic wr_en_bit,
  output logic evt_q,
  output logic en_q,
  output logic flag_q
);

  logic evt_d;
  logic en_d;
  logic flag_d;
  logic cond_now;
  logic cond_nxt;
  logic flag_set;

  always_comb begin
    // an edge arriving with the clearing read keeps the event
    evt_d    = lnk_edge | (evt_q & ~rd_int);
    en_d     = en_q;
    if (wr_int) en_d = wr_en_bit;
    cond_now = evt_q & en_q;
    cond_nxt = evt_d & en_d;
    flag_set = cond_nxt & ~cond_now;
    flag_d   = flag_set | (flag_q & ~rd_sts);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      evt_q  <= evt_d;
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (wr_int) begin
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/lnk_irq_regs.sv
module lnk_irq_regs
  import lnk_irq_pkg::*;
#(
  parameter int                ADDR_W   = 5,
  parameter logic [ADDR_W-1:0] STS_ADDR = ADDR_W'('h10),
  parameter logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'('h11),
  parameter logic [ADDR_W-1:0] INT_ADDR = ADDR_W'('h12)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_cs,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              lnk_sync,
  input  logic              evt_q,
  input  logic              en_q,
  input  logic              flag_q,
  output logic              rd_sts,
  output logic              rd_int,
  output logic              wr_int,
  output logic              wr_en_bit,
  output pin_cfg_t          cfg_q,
  output logic [REG_W-1:0]  reg_rdata
);

  reg_sel_e          sel;
  logic              rd_stb;
  logic              wr_stb;
  logic              wr_cfg;
  pin_cfg_t          cfg_d;
  logic [REG_W-1:0]  rd_mux;
  logic [REG_W-1:0]  rdata_q;
  logic              wdata_unused;

  always_comb begin
    sel = SEL_NONE;
    if (reg_addr == STS_ADDR)      sel = SEL_STS;
    else if (reg_addr == CFG_ADDR) sel = SEL_CFG;
    else if (reg_addr == INT_ADDR) sel = SEL_INT;
  end

  always_comb begin
    rd_stb    = reg_cs & ~reg_we;
    wr_stb    = reg_cs & reg_we;
    rd_sts    = rd_stb & (sel == SEL_STS);
    rd_int    = rd_stb & (sel == SEL_INT);
    wr_int    = wr_stb & (sel == SEL_INT);
    wr_cfg    = wr_stb & (sel == SEL_CFG);
    wr_en_bit = reg_wdata[INT_EN_BIT];
    cfg_d.pol = reg_wdata[CFG_POL_BIT];
    cfg_d.ie  = reg_wdata[CFG_IE_BIT];
    cfg_d.oe  = reg_wdata[CFG_OE_BIT];
  end

  assign wdata_unused = ^{reg_wdata[REG_W-1:INT_EN_BIT+1],
                          reg_wdata[INT_EN_BIT-1:CFG_POL_BIT+1],
                          reg_wdata[CFG_IE_BIT+1]};

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_STS: begin
        rd_mux[STS_LINK_BIT] = lnk_sync;
        rd_mux[STS_SUM_BIT]  = flag_q;
      end
      SEL_CFG: begin
        rd_mux[CFG_POL_BIT] = cfg_q.pol;
        rd_mux[CFG_IE_BIT]  = cfg_q.ie;
        rd_mux[CFG_OE_BIT]  = cfg_q.oe;
      end
      SEL_INT: begin
        rd_mux[INT_EVT_BIT] = evt_q;
        rd_mux[INT_EN_BIT]  = en_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_cfg) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_stb) begin
      rdata_q <= rd_mux;
    end
  end

  assign reg_rdata = rdata_q;

endmodule

// File: rtl/lnk_irq_pin.sv
module lnk_irq_pin
  import lnk_irq_pkg::*;
(
  input  pin_cfg_t cfg,
  input  logic     evt_q,
  input  logic     en_q,
  output logic     irq_out,
  output logic     irq_oe
);

  logic active;

  always_comb begin
    active  = cfg.ie & evt_q & en_q;
    irq_out = active ? cfg.pol : ~cfg.pol;
    irq_oe  = cfg.oe;
  end

endmodule

// File: rtl/lnk_irq_ctrl.sv
module lnk_irq_ctrl
  import lnk_irq_pkg::*;
#(
  parameter int                ADDR_W      = 5,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] STS_ADDR    = ADDR_W'('h10),
  parameter logic [ADDR_W-1:0] CFG_ADDR    = ADDR_W'('h11),
  parameter logic [ADDR_W-1:0] INT_ADDR    = ADDR_W'('h12)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_in,
  input  logic              reg_cs,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq_out,
  output logic              irq_oe
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_q;
  logic                  rst_i;
  logic                  lnk_sync;
  logic                  lnk_edge;
  logic                  evt_pend;
  logic                  evt_en;
  logic                  sum_flag;
  logic                  rd_sts;
  logic                  rd_int;
  logic                  wr_int;
  logic                  wr_en_bit;
  pin_cfg_t              pin_cfg;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_i = rst_q[RST_STAGES-1];

  lnk_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_i),
    .link_in  (link_in),
    .lnk_sync (lnk_sync),
    .lnk_edge (lnk_edge)
  );

  lnk_irq_evt u_evt (
    .clk       (clk),
    .rst_n     (rst_i),
    .lnk_edge  (lnk_edge),
    .rd_int    (rd_int),
    .rd_sts    (rd_sts),
    .wr_int    (wr_int),
    .wr_en_bit (wr_en_bit),
    .evt_q     (evt_pend),
    .en_q      (evt_en),
    .flag_q    (sum_flag)
  );

  lnk_irq_regs #(
    .ADDR_W   (ADDR_W),
    .STS_ADDR (STS_ADDR),
    .CFG_ADDR (CFG_ADDR),
    .INT_ADDR (INT_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_i),
    .reg_cs    (reg_cs),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .lnk_sync  (lnk_sync),
    .evt_q     (evt_pend),
    .en_q      (evt_en),
    .flag_q    (sum_flag),
    .rd_sts    (rd_sts),
    .rd_int    (rd_int),
    .wr_int    (wr_int),
    .wr_en_bit (wr_en_bit),
    .cfg_q     (pin_cfg),
    .reg_rdata (reg_rdata)
  );

  lnk_irq_pin u_pin (
    .cfg     (pin_cfg),
    .evt_q   (evt_pend),
    .en_q    (evt_en),
    .irq_out (irq_out),
    .irq_oe  (irq_oe)
  );

endmodule

// File: rtl/lnk_irq_ctrl_chk.sv
module lnk_irq_ctrl_chk #(
  parameter int                ADDR_W   = 5,
  parameter logic [ADDR_W-1:0] STS_ADDR = ADDR_W'('h10),
  parameter logic [ADDR_W-1:0] INT_ADDR = ADDR_W'('h12)
) (
  input logic              clk,
  input logic              rst_i,
  input logic              reg_cs,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              wdata_en,
  input logic [15:0]       reg_rdata,
  input logic              irq_out,
  input logic              evt,
  input logic              en,
  input logic              flag,
  input logic              cfg_pol,
  input logic              cfg_ie
);

  AST_FLAG_NO_WRITE_CLR: assert property (@(posedge clk) disable iff (!rst_i)
    (flag && reg_cs && reg_we && reg_addr == STS_ADDR) |=> flag); // R6

  AST_EVT_HELD: assert property (@(posedge clk) disable iff (!rst_i)
    (evt && !(reg_cs && !reg_we && reg_addr == INT_ADDR)) |=> evt); // R3

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_i)
    (reg_cs && reg_we && reg_addr == INT_ADDR) |=> (en == $past(wdata_en))); // R4

  AST_FLAG_RISE_COND: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(flag) |-> (evt && en)); // R5

  AST_PIN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg_ie && evt && en) |-> (irq_out == cfg_pol)); // R7

  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_i)
    !(cfg_ie && evt && en) |-> (irq_out != cfg_pol)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    !(reg_cs && !reg_we) |=> $stable(reg_rdata)); // R11

endmodule

bind lnk_irq_ctrl lnk_irq_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .STS_ADDR (STS_ADDR),
  .INT_ADDR (INT_ADDR)
) u_chk (
  .clk       (clk),
  .rst_i     (rst_i),
  .reg_cs    (reg_cs),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .wdata_en  (reg_wdata[5]),
  .reg_rdata (reg_rdata),
  .irq_out   (irq_out),
  .evt       (evt_pend),
  .en        (evt_en),
  .flag      (sum_flag),
  .cfg_pol   (pin_cfg.pol),
  .cfg_ie    (pin_cfg.ie)
);

// File: tb/lnk_irq_ctrl_bench.sv
module lnk_irq_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int WATCHDOG   = 20000;
  localparam logic [4:0] A_STS = 5'h10;
  localparam logic [4:0] A_CFG = 5'h11;
  localparam logic [4:0] A_INT = 5'h12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        link_in;
  logic        reg_cs;
  logic        reg_we;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq_out;
  logic        irq_oe;

  int total = 0;
  int bad   = 0;
  bit fin   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lnk_irq_ctrl u_lnk_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_in   (link_in),
    .reg_cs    (reg_cs),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_out   (irq_out),
    .irq_oe    (irq_oe)
  );

  // behavioural reference, advanced on each rising edge
  bit m_q[$];
  bit m_prev, m_evt, m_en, m_flag, m_pol, m_ie, m_oe;
  int m_rdata;
  int m_rel;
  bit m_started = 0;

  function automatic int m_read(input logic [4:0] a);
    if (a == A_STS) return (int'(m_flag) << 7) | int'(m_q[SYNC-1]);
    if (a == A_CFG) return (int'(m_pol) << 3) | (int'(m_ie) << 1) | int'(m_oe);
    if (a == A_INT) return (int'(m_evt) << 13) | (int'(m_en) << 5);
    return 0;
  endfunction

  task automatic m_clear();
    m_q.delete();
    for (int i = 0; i < SYNC; i++) m_q.push_back(1'b0);
    m_prev = 0; m_evt = 0; m_en = 0; m_flag = 0;
    m_pol = 0; m_ie = 0; m_oe = 0; m_rdata = 0;
  endtask

  always @(posedge clk) begin
    m_started = 1;
    if (!rst_n) begin
      m_rel = 0;
      m_clear();
    end else if (m_rel < 2) begin
      m_rel++;
      m_clear();
    end else begin
      bit edge_now, rd, wr, evt_n, en_n, cond_o, cond_n;
      edge_now = m_q[SYNC-1] ^ m_prev;
      rd = reg_cs && !reg_we;
      wr = reg_cs && reg_we;
      evt_n = edge_now || (m_evt && !(rd && reg_addr == A_INT));
      en_n  = (wr && reg_addr == A_INT) ? reg_wdata[5] : m_en;
      cond_o = m_evt && m_en;
      cond_n = evt_n && en_n;
      if (rd) m_rdata = m_read(reg_addr);
      m_flag = (cond_n && !cond_o) || (m_flag && !(rd && reg_addr == A_STS));
      if (wr && reg_addr == A_CFG) begin
        m_pol = reg_wdata[3]; m_ie = reg_wdata[1]; m_oe = reg_wdata[0];
      end
      m_evt = evt_n;
      m_en  = en_n;
      m_prev = m_q[SYNC-1];
      m_q.push_front(link_in);
      void'(m_q.pop_back());
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (m_started && !fin) begin
      bit exp_out;
      exp_out = (m_ie && m_evt && m_en) ? m_pol : !m_pol;
      check("R11 rdata vs model", int'(reg_rdata), m_rdata);
      check("R7 irq_out vs model", int'(irq_out), int'(exp_out));
      check("R9 irq_oe vs model", int'(irq_oe), int'(m_oe));
    end
  end

  task automatic do_write(input logic [4:0] a, input logic [15:0] d);
    reg_cs = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_cs = 0; reg_we = 0; reg_wdata = '0;
  endtask

  task automatic do_read(input logic [4:0] a, output logic [15:0] d);
    reg_cs = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    reg_cs = 0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!fin) begin
      fin = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired act=running exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    rst_n = 0; link_in = 0; reg_cs = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
    idle(3);
    rst_n = 1;
    idle(3);
    // reset state
    check("R9 reset oe", int'(irq_oe), 0);
    check("R8 reset pin idle high (active-low default)", int'(irq_out), 1);
    check("R11 reset rdata", int'(reg_rdata), 0);
    do_read(A_STS, rd); check("R1 reset status", int'(rd), 'h0000);
    do_read(A_INT, rd); check("R4 reset interrupt reg", int'(rd), 'h0000);

    // configuration read-back: only bits 3,1,0 stick
    do_write(A_CFG, 16'hFFFF);
    do_read(A_CFG, rd); check("R10 cfg readback", int'(rd), 'h000B);
    check("R9 oe on", int'(irq_oe), 1);
    check("R8 idle low when active-high", int'(irq_out), 0);

    // enable written, event bit write ignored
    do_write(A_INT, 16'h2020);
    do_read(A_INT, rd); check("R4 event bit not writable", int'(rd), 'h0020);

    // link up: event, flag, pin
    link_in = 1;
    idle(5);
    check("R7 pin active on enabled event", int'(irq_out), 1);
    do_read(A_STS, rd); check("R1 R2 R5 status link+flag", int'(rd), 'h0081);
    do_read(A_STS, rd); check("R6 flag cleared by read", int'(rd), 'h0001);
    check("R7 pin held after flag clear", int'(irq_out), 1);
    do_read(A_INT, rd); check("R2 R3 event reported", int'(rd), 'h2020);
    check("R3 pin released after event read", int'(irq_out), 0);
    do_read(A_INT, rd); check("R3 event cleared", int'(rd), 'h0020);

    // link down, status write must not clear flag
    link_in = 0;
    idle(5);
    do_write(A_STS, 16'h0000);
    do_read(A_STS, rd); check("R6 write does not clear flag", int'(rd), 'h0080);

    // masking keeps the event; re-enable raises flag again
    do_write(A_INT, 16'h0000);
    check("R4 mask releases pin", int'(irq_out), 0);
    do_write(A_INT, 16'h0020);
    check("R4 unmask re-asserts pin", int'(irq_out), 1);
    do_read(A_STS, rd); check("R5 flag on re-enable of pending event", int'(rd), 'h0080);
    do_read(A_INT, rd); check("R4 event kept through mask", int'(rd), 'h2020);

    // global interrupt enable off
    do_write(A_CFG, 16'h0009);
    link_in = 1;
    idle(5);
    check("R7 global enable gates pin", int'(irq_out), 0);
    do_read(A_STS, rd); check("R5 flag independent of global enable", int'(rd), 'h0081);
    do_read(A_INT, rd); check("R2 event with global enable off", int'(rd), 'h2020);

    // active-low polarity
    do_write(A_CFG, 16'h0003);
    check("R8 active-low idle level", int'(irq_out), 1);
    link_in = 0;
    idle(5);
    check("R8 active-low asserted", int'(irq_out), 0);
    do_read(A_INT, rd);
    check("R8 active-low released", int'(irq_out), 1);

    // output enable off, read hold, unmapped address
    do_write(A_CFG, 16'h0002);
    check("R9 oe off", int'(irq_oe), 0);
    do_read(A_CFG, rd); check("R10 cfg readback ie only", int'(rd), 'h0002);
    idle(3);
    check("R11 rdata holds without strobe", int'(reg_rdata), 'h0002);
    do_read(5'h05, rd); check("R10 unmapped address", int'(rd), 'h0000);

    // edge landing in the same cycle as the interrupt read
    do_read(A_STS, rd);
    link_in = 1;
    idle(2);
    do_read(A_INT, rd); check("R3 read during edge sees old", int'(rd), 'h0020);
    do_read(A_INT, rd); check("R3 edge wins over clear", int'(rd), 'h2020);

    idle(2);
    fin = 1;
    summary();
    $finish;
  end

endmodule